// File: doc/BRIEF.md
# Error-tagged receive FIFO

This block is the receive-side store of a serial port. A controller pushes received characters in, and a host pulls them out. Each stored entry is eleven bits wide: the character byte in bits 0-7 and three per-character error indications in bits 8-10. Loading an entry takes two steps. The controller first places the error indications in a shadow register. A later data write then stores the byte and the current shadow contents together as one word.

When the host reads an entry, the byte appears on the read data output. The three error bits of the same entry are copied into a status image, which a host-side status register places at its bits 2-4. The block also produces the occupancy count and the full, empty and trigger-level flags, and it raises a receive interrupt. The interrupt is asserted when the occupancy reaches a selectable threshold, or when characters have sat unread with no traffic for a programmable number of clock cycles.

A mode input chooses between the full sixteen-entry queue and a single holding register. Any change of that input discards the stored contents.

Top module: `rx_err_fifo`

## Requirements
- R1: After a synchronous active-high reset, count is 0, empty is 1, and full, almost_full, timeout_flag, rx_irq, overrun, rd_data and lsr_err are all 0.
- R2: A pulse on err_wr loads err_in into the shadow register, and the shadow keeps that value until the next err_wr. An accepted data_wr stores data_in in bits 0-7 of the word and the shadow value in bits 8-10, where bit 8 is parity, bit 9 is framing and bit 10 is break. When err_wr and data_wr occur in the same cycle, the word takes the shadow value from before that cycle.
- R3: Entries leave in the order they were written. After an accepted read at a clock edge, rd_data holds the entry's byte from that edge on, and lsr_err holds its bits 8-10: lsr_err[0] is parity, lsr_err[1] is framing and lsr_err[2] is break, which are status bits 2, 3 and 4.
- R4: count is the number of stored entries. empty is 1 exactly when count is 0. full is 1 exactly when count equals the capacity, which is 16 in queue mode and 1 in holding mode. All three update at the same edge as the accepted access.
- R5: almost_full is 1 when count is at least the trigger level. In queue mode trig_sel selects the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. In holding mode the level is 1.
- R6: A read and a write in the same cycle both take effect, including when the store is full. In that case count stays the same and the new word follows the remaining entries.
- R7: A write with no read while the store is full is discarded, leaving count and contents unchanged, and sets overrun. overrun then stays 1 until reset.
- R8: A read while the store is empty changes nothing: rd_data, lsr_err and count keep their values.
- R9: After cfg_timeout consecutive cycles with the store non-empty and neither rd nor data_wr asserted, timeout_flag becomes 1. It clears at the edge of any rd or data_wr, and whenever the store is empty. A cfg_timeout of 0 disables the time-out.
- R10: rx_irq is 1 exactly when almost_full or timeout_flag is 1.
- R11: cfg_fifo_en set to 1 selects queue mode and set to 0 selects holding mode. At the first edge after cfg_fifo_en changes, the store is emptied, timeout_flag clears, and any read or write in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects one holding register |
| cfg_trig_sel | input | 2 | Trigger level select (00=1, 01=4, 10=8, 11=14) |
| cfg_timeout | input | 16 | Idle cycles before time-out, 0 disables it |
| err_wr | input | 1 | Load err_in into the shadow register |
| err_in | input | 3 | Error bits {break, framing, parity} |
| data_wr | input | 1 | Push data_in together with the shadow bits |
| data_in | input | 8 | Received character |
| rd | input | 1 | Pop the oldest entry |
| rd_data | output | 8 | Byte of the last entry read |
| lsr_err | output | 3 | Error bits of the last entry read, status bits 2-4 |
| count | output | 5 | Number of stored entries |
| full | output | 1 | Store holds its capacity |
| empty | output | 1 | Store holds nothing |
| almost_full | output | 1 | count is at or above the trigger level |
| timeout_flag | output | 1 | Unread data has waited the time-out period |
| overrun | output | 1 | Sticky: a write was dropped while full |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Each result is due at a fixed edge. rd_data and lsr_err change at the same rising edge that samples an accepted rd. count, full, empty, almost_full and overrun change at the edge of the accepted or dropped access. timeout_flag rises at the edge that completes the cfg_timeout-th idle cycle. The bench drives inputs and compares every output on the falling clock edge. Its reference model advances at each rising edge from the inputs alone, so each comparison falls half a cycle after the edge whose effect it checks. The directed checks are arranged so that each expected value is read on the exact cycle in which it is due.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  localparam int ERR_BITS = $bits(rx_err_t);

endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; old data is returned on a same-address collision
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int CW     = 5,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          overrun
);

  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_n, cap, trig;
  logic [AW-1:0] wp_q, rp_q;
  logic          full_q, empty_q, af_q, ovr_q;

  always_comb begin
    cap = fifo_en ? CAP_Q : ONE;
    unique case (trig_sel)
      2'd0:    trig = CW'(TRIG_0);
      2'd1:    trig = CW'(TRIG_1);
      2'd2:    trig = CW'(TRIG_2);
      default: trig = CW'(TRIG_3);
    endcase
    if (!fifo_en) trig = ONE;
  end

  assign rd_ok = rd_req && !empty_q && !flush;
  assign wr_ok = wr_req && !flush && ((cnt_q < cap) || rd_ok);

  always_comb begin
    cnt_n = cnt_q;
    if (flush)               cnt_n = '0;
    else if (wr_ok && !rd_ok) cnt_n = cnt_q + ONE;
    else if (rd_ok && !wr_ok) cnt_n = cnt_q - ONE;
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      af_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (flush) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (wr_ok) wp_q <= bump(wp_q);
        if (rd_ok) rp_q <= bump(rp_q);
      end
      cnt_q   <= cnt_n;
      full_q  <= (cnt_n == cap);
      empty_q <= (cnt_n == '0);
      af_q    <= (cnt_n >= trig);
      if (wr_req && !wr_ok && !flush) ovr_q <= 1'b1;
    end
  end

  assign wr_ptr      = wp_q;
  assign rd_ptr      = rp_q;
  assign count       = cnt_q;
  assign full        = full_q;
  assign empty       = empty_q;
  assign almost_full = af_q;
  assign overrun     = ovr_q;

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            activity,
  input  logic            empty,
  input  logic [TO_W-1:0] limit,
  output logic            fired
);

  logic [TO_W-1:0] idle_q;
  logic            fired_q;
  logic [TO_W-1:0] idle_n;

  assign idle_n = idle_q + TO_W'(1);

  always_ff @(posedge clk) begin
    if (rst || flush || activity || empty) begin
      idle_q  <= '0;
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      idle_q <= idle_n;
      if (limit != '0 && idle_n == limit) fired_q <= 1'b1;
    end
  end

  assign fired = fired_q;

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int TO_W   = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_fifo_en,
  input  logic [1:0]               cfg_trig_sel,
  input  logic [TO_W-1:0]          cfg_timeout,
  input  logic                     err_wr,
  input  logic [ERR_BITS-1:0]      err_in,
  input  logic                     data_wr,
  input  logic [DATA_W-1:0]        data_in,
  input  logic                     rd,
  output logic [DATA_W-1:0]        rd_data,
  output logic [ERR_BITS-1:0]      lsr_err,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                     full,
  output logic                     empty,
  output logic                     almost_full,
  output logic                     timeout_flag,
  output logic                     overrun,
  output logic                     rx_irq
);

  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int WORD_W = DATA_W + ERR_BITS;

  rx_err_t           shadow_q;
  logic              fifo_en_q;
  logic              flush;
  logic              wr_ok, rd_ok;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [WORD_W-1:0] rd_word;

  // shadow status bits and mode history
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      fifo_en_q <= cfg_fifo_en;
    end else begin
      if (err_wr) shadow_q <= rx_err_t'(err_in);
      fifo_en_q <= cfg_fifo_en;
    end
  end

  assign flush = (cfg_fifo_en != fifo_en_q);

  rxf_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .CW(CW),
    .TRIG_0(TRIG_0), .TRIG_1(TRIG_1), .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)
  ) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .fifo_en(cfg_fifo_en),
    .trig_sel(cfg_trig_sel), .wr_req(data_wr), .rd_req(rd),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .full(full), .empty(empty),
    .almost_full(almost_full), .overrun(overrun)
  );

  rxf_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_ok), .waddr(wr_ptr), .wdata({shadow_q, data_in}),
    .re(rd_ok), .raddr(rd_ptr), .rdata(rd_word)
  );

  rxf_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst(rst), .flush(flush), .activity(data_wr | rd),
    .empty(empty), .limit(cfg_timeout), .fired(timeout_flag)
  );

  assign rd_data = rd_word[DATA_W-1:0];
  assign lsr_err = rd_word[WORD_W-1:DATA_W];
  assign rx_irq  = almost_full | timeout_flag;

endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_fifo_en,
  input logic          en_q,
  input logic          data_wr,
  input logic          rd,
  input logic [7:0]    rd_data,
  input logic [2:0]    lsr_err,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          almost_full,
  input logic          timeout_flag,
  input logic          overrun
);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_no_af_empty_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> !almost_full);

  p_drop_full_r7: assert property (@(posedge clk) disable iff (rst)
    (full && data_wr && !rd && cfg_fifo_en == en_q) |=> (full && overrun));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_empty_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (empty && rd) |=> ($stable(rd_data) && $stable(lsr_err)));

  p_timeout_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (data_wr || rd) |=> !timeout_flag);

  p_flush_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo_en != en_q) |=> (empty && !timeout_flag));

  p_hold_cap_r11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo_en && !en_q) |-> (count <= CW'(1)));

endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .en_q(fifo_en_q),
  .data_wr(data_wr), .rd(rd), .rd_data(rd_data), .lsr_err(lsr_err),
  .count(count), .full(full), .empty(empty), .almost_full(almost_full),
  .timeout_flag(timeout_flag), .overrun(overrun)
);

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_fifo_en;
  logic [1:0]  cfg_trig_sel;
  logic [15:0] cfg_timeout;
  logic        err_wr;
  logic [2:0]  err_in;
  logic        data_wr;
  logic [7:0]  data_in;
  logic        rd;
  logic [7:0]  rd_data;
  logic [2:0]  lsr_err;
  logic [4:0]  count;
  logic        full, empty, almost_full, timeout_flag, overrun, rx_irq;

  always #4 clk = ~clk;

  rx_err_fifo u0 (
    .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_trig_sel(cfg_trig_sel),
    .cfg_timeout(cfg_timeout), .err_wr(err_wr), .err_in(err_in),
    .data_wr(data_wr), .data_in(data_in), .rd(rd), .rd_data(rd_data),
    .lsr_err(lsr_err), .count(count), .full(full), .empty(empty),
    .almost_full(almost_full), .timeout_flag(timeout_flag),
    .overrun(overrun), .rx_irq(rx_irq)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [10:0] m_mem [16];
  int          m_rp, m_wp, m_cnt, m_timer;
  logic [10:0] m_rd;
  logic [2:0]  m_sh;
  logic        m_enq, m_to, m_ovr, m_full, m_empty, m_af;

  function automatic int cap_of(logic en);
    return en ? 16 : 1;
  endfunction

  function automatic int trig_of(logic en, logic [1:0] sel);
    if (!en) return 1;
    case (sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rp = 0; m_wp = 0; m_cnt = 0; m_timer = 0; m_rd = '0; m_sh = '0;
      m_enq = cfg_fifo_en; m_to = 0; m_ovr = 0;
    end else begin
      bit flush, rok, wok;
      flush = (cfg_fifo_en != m_enq);
      if (flush || data_wr || rd || m_cnt == 0) begin
        m_timer = 0; m_to = 0;
      end else if (!m_to) begin
        m_timer = m_timer + 1;
        if (cfg_timeout != 0 && m_timer == int'(cfg_timeout)) m_to = 1;
      end
      if (flush) begin
        m_cnt = 0; m_rp = 0; m_wp = 0;
      end else begin
        rok = rd && m_cnt != 0;
        wok = data_wr && (m_cnt < cap_of(cfg_fifo_en) || rok);
        if (data_wr && !wok) m_ovr = 1;
        if (rok) begin m_rd = m_mem[m_rp]; m_rp = (m_rp + 1) % 16; end
        if (wok) begin m_mem[m_wp] = {m_sh, data_in}; m_wp = (m_wp + 1) % 16; end
        m_cnt = m_cnt + int'(wok) - int'(rok);
      end
      if (err_wr) m_sh = err_in;
      m_enq = cfg_fifo_en;
    end
    m_full  = (m_cnt == cap_of(cfg_fifo_en));
    m_empty = (m_cnt == 0);
    m_af    = (m_cnt >= trig_of(cfg_fifo_en, cfg_trig_sel));
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3", "rd_data", int'(rd_data), int'(m_rd[7:0]));
    chk("R3", "lsr_err", int'(lsr_err), int'(m_rd[10:8]));
    chk("R4", "count", int'(count), m_cnt);
    chk("R4", "full", int'(full), int'(m_full));
    chk("R4", "empty", int'(empty), int'(m_empty));
    chk("R5", "almost_full", int'(almost_full), int'(m_af));
    chk("R9", "timeout_flag", int'(timeout_flag), int'(m_to));
    chk("R7", "overrun", int'(overrun), int'(m_ovr));
    chk("R10", "rx_irq", int'(rx_irq), int'(m_af | m_to));
  endtask

  task automatic idle_in();
    err_wr = 0; data_wr = 0; rd = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle_in();
  endtask

  task automatic push(input logic [7:0] d);
    data_wr = 1; data_in = d; cyc();
  endtask

  task automatic pop();
    rd = 1; cyc();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] held;
    int seed;
    seed = $urandom(32'd2024);
    rst = 1; cfg_fifo_en = 1; cfg_trig_sel = 2'd3; cfg_timeout = 16'd0;
    err_in = 0; data_in = 0; idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "flags", int'({full, almost_full, timeout_flag, overrun, rx_irq}), 0);
    chk("R1", "rd_data", int'({rd_data, lsr_err}), 0);
    cyc();

    // R2: shadow capture, same-cycle err_wr uses the older shadow
    err_wr = 1; err_in = 3'b101; cyc();
    err_wr = 1; err_in = 3'b010; push(8'hA5);
    push(8'h3C);
    pop();
    chk("R2", "byte", int'(rd_data), 8'hA5);
    chk("R2", "err bits old shadow", int'(lsr_err), 5);
    pop();
    chk("R2", "err bits new shadow", int'(lsr_err), 2);

    // R4/R7: fill, then overflow
    for (int i = 0; i < 16; i++) push(8'(i + 16));
    chk("R4", "full at 16", int'(full), 1);
    push(8'hEE);
    chk("R7", "overrun set", int'(overrun), 1);
    chk("R7", "count kept", int'(count), 16);

    // R6: read and write together while full
    rd = 1; push(8'h77);
    chk("R6", "count at full rw", int'(count), 16);
    chk("R6", "read oldest", int'(rd_data), 16);

    // drain, then R8 read on empty
    for (int i = 0; i < 16; i++) pop();
    chk("R6", "new word last", int'(rd_data), 8'h77);
    chk("R4", "empty after drain", int'(empty), 1);
    held = rd_data;
    pop();
    chk("R8", "empty read holds", int'(rd_data), int'(held));
    chk("R8", "count stays 0", int'(count), 0);

    // R5/R10: trigger level 4
    cfg_trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) push(8'(i));
    chk("R5", "below level", int'(almost_full), 0);
    push(8'h03);
    chk("R5", "at level", int'(almost_full), 1);
    chk("R10", "irq on level", int'(rx_irq), 1);

    // R9: time-out after 5 idle cycles
    cfg_trig_sel = 2'd3; cfg_timeout = 16'd5;
    repeat (4) cyc();
    chk("R9", "not yet", int'(timeout_flag), 0);
    cyc();
    chk("R9", "fired", int'(timeout_flag), 1);
    chk("R10", "irq on timeout", int'(rx_irq), 1);
    pop();
    chk("R9", "cleared by read", int'(timeout_flag), 0);

    // R11: switch to holding mode flushes; capacity 1
    cfg_fifo_en = 0; cyc();
    chk("R11", "flushed", int'(count), 0);
    push(8'h55);
    chk("R11", "full at 1", int'(full), 1);
    push(8'h66);
    chk("R11", "second dropped", int'(count), 1);
    pop();
    chk("R11", "holding byte", int'(rd_data), 8'h55);
    cfg_fifo_en = 1; cyc();

    // constrained random phase
    cfg_timeout = 16'd6;
    for (int n = 0; n < 4000; n++) begin
      data_wr = ($urandom % 100) < 50;
      rd      = ($urandom % 100) < 40;
      err_wr  = ($urandom % 100) < 30;
      err_in  = 3'($urandom);
      data_in = 8'($urandom);
      if (($urandom % 64) == 0) cfg_trig_sel = 2'($urandom);
      if (($urandom % 300) == 0) cfg_fifo_en = ~cfg_fifo_en;
      if (($urandom % 50) == 0) begin data_wr = 0; rd = 0; repeat (8) cyc(); end
      else cyc();
    end

    summary();
    $finish;
  end

endmodule